// File: doc/BRIEF.md
# Spread-Spectrum Four-Channel PWM

This block drives four pulse-width-modulated lines from one shared 10-bit counter. The counter moves forward only on cycles where an enable pulse arrives from an external prescaler. One full sweep of 1024 enabled counts forms a frame. Each channel owns a 10-bit high-time value. Software writes it as two bytes: a high byte and a low byte. The low byte also carries the channel's options.

There are two options per channel. The first is spreading. With spreading on, the high time is not one contiguous pulse at the start of the frame. It is split into four shorter pulses, one at the start of each 256-count quadrant. The upper eight bits of the value give every quadrant its base length. The lower two bits add one extra count to that many quadrants, beginning with quadrant 0, so the total high time still equals the 10-bit value.

The second option is suppression. It blanks the output on a fixed share of frames, using a small frame counter that all channels share. Written bytes first land in pending registers. A channel's active settings reload only at the frame wrap, so no frame ever mixes old and new settings.

Top module: `ss_pwm`

## Requirements
- R1: The counter is 10 bits wide, starts at 0 after reset and increments by one on every clock where `tick_i` is high. It wraps from 1023 to 0, so a frame is exactly 1024 enabled counts.
- R2: A write with `wr_en_i` high targets channel `wr_addr_i[2:1]`. When `wr_addr_i[0]`=1, `wr_data_i` becomes value bits 9:2. When `wr_addr_i[0]`=0, `wr_data_i[7:6]` become value bits 1:0, `wr_data_i[5:4]` become the suppression code and `wr_data_i[0]` becomes the spread enable. Bits 3:1 of that byte have no effect.
- R3: Written settings reach the output only from the first count of the next frame, and the frame in progress is unaffected. A byte written in the same cycle as the wrap from 1023 to 0 already applies to the new frame.
- R4: With spreading off, a channel with value W is high for counts 0 to W-1 and low for the rest of the frame. W=0 gives no high count at all.
- R5: With spreading on, in quadrant q (counter bits 9:8) the channel is high while counter bits 7:0 are below W[9:2] plus one if q < W[1:0]. The total high time per frame is W.
- R6: A 3-bit frame counter starts at 0 and advances once per wrap. Suppression code 00 passes every frame. Code 01 passes only frames where the counter is 0 mod 8, code 10 only frames where it is 0 mod 4, and code 11 only frames where it is 0 mod 2. All other frames are forced low.
- R7: While `tick_i` is low, the counter, the frame counter and all outputs hold their values.
- R8: While `rst_ni` is low, all outputs are low. After reset, every setting is zero, so the outputs stay low until a setting is written.
- R9: Each channel's output depends only on its own settings. A write to one channel never changes another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter enable pulse from the prescaler |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 3 | Channel (bits 2:1) and byte select (bit 0, 1 = high byte) |
| wr_data_i | input | 8 | Write data byte |
| pwm_o | output | 4 | PWM outputs, one per channel |

## Verification
A register write and the frame reload can fall in the same cycle. This happens when a byte is written on the clock that takes the counter from 1023 to 0. The bench provokes it by writing a channel's high byte at count 1022 and its low byte at count 1023. It then checks that the new value shapes the whole next frame, with a per-sample comparison and a total high-count check. A second collision, a stalled prescaler in the middle of a frame, is checked by holding `tick_i` low and confirming that no output sample moves.

// File: rtl/ss_pwm_pkg.sv
package ss_pwm_pkg;
  localparam int unsigned CNT_W  = 10;
  localparam int unsigned QUAD_W = 2;
  localparam int unsigned GRP_W  = 3;

  typedef enum logic [1:0] {
    SUP_NONE = 2'b00,
    SUP_7OF8 = 2'b01,
    SUP_3OF4 = 2'b10,
    SUP_1OF2 = 2'b11
  } sup_e;

  typedef struct packed {
    logic [CNT_W-1:0] width;
    sup_e             sup;
    logic             spread;
  } chan_cfg_t;
endpackage

// File: rtl/ss_pwm_timebase.sv
module ss_pwm_timebase #(
  parameter int unsigned CW = 10,
  parameter int unsigned GW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic [GW-1:0] grp_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;
  logic [GW-1:0] grp_q;

  assign wrap_o = tick_i && (cnt_q == {CW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      grp_q <= '0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (wrap_o) grp_q <= grp_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign grp_o = grp_q;
endmodule

// File: rtl/ss_pwm_regs.sv
module ss_pwm_regs
  import ss_pwm_pkg::*;
#(
  parameter int unsigned CH = 4,
  parameter int unsigned CW = 10,
  parameter int unsigned QW = 2,
  localparam int unsigned AW = $clog2(CH) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic                 wrap_i,
  output chan_cfg_t [CH-1:0]   act_o
);
  localparam int unsigned CHW = AW - 1;

  for (genvar ch = 0; ch < CH; ch++) begin : g_ch
    chan_cfg_t pend_q, act_q, nxt;
    logic      hit;

    assign hit = wr_en_i && (wr_addr_i[AW-1:1] == CHW'(ch));

    // merge the incoming byte so a write on the wrap cycle lands in the new frame
    always_comb begin
      nxt = pend_q;
      if (hit) begin
        if (wr_addr_i[0]) begin
          nxt.width[CW-1:QW] = wr_data_i;
        end else begin
          nxt.width[QW-1:0] = wr_data_i[7:6];
          nxt.sup           = sup_e'(wr_data_i[5:4]);
          nxt.spread        = wr_data_i[0];
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= '0;
        act_q  <= '0;
      end else begin
        pend_q <= nxt;
        if (wrap_i) act_q <= nxt;
      end
    end

    assign act_o[ch] = act_q;
  end
endmodule

// File: rtl/ss_pwm_chan.sv
module ss_pwm_chan
  import ss_pwm_pkg::*;
#(
  parameter int unsigned CW = 10,
  parameter int unsigned QW = 2,
  parameter int unsigned GW = 3
) (
  input  chan_cfg_t     cfg_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [GW-1:0] grp_i,
  output logic          pwm_o
);
  localparam int unsigned OW = CW - QW;

  logic [OW-1:0] base;
  logic [QW-1:0] extra, quad;
  logic [OW-1:0] off;
  logic [OW:0]   len;
  logic          quad_lt, spread_hi, flat_hi, pass;

  assign base    = cfg_i.width[CW-1:QW];
  assign extra   = cfg_i.width[QW-1:0];
  assign quad    = cnt_i[CW-1:OW];
  assign off     = cnt_i[OW-1:0];
  assign quad_lt = (quad < extra);
  assign len     = {1'b0, base} + {{OW{1'b0}}, quad_lt};

  assign spread_hi = ({1'b0, off} < len);
  assign flat_hi   = (cnt_i < cfg_i.width);

  always_comb begin
    unique case (cfg_i.sup)
      SUP_7OF8: pass = (grp_i == '0);
      SUP_3OF4: pass = (grp_i[1:0] == 2'b00);
      SUP_1OF2: pass = !grp_i[0];
      default:  pass = 1'b1;
    endcase
  end

  assign pwm_o = pass && (cfg_i.spread ? spread_hi : flat_hi);
endmodule

// File: rtl/ss_pwm.sv
module ss_pwm
  import ss_pwm_pkg::*;
#(
  parameter int unsigned CH = 4,
  parameter int unsigned CW = CNT_W,
  parameter int unsigned QW = QUAD_W,
  parameter int unsigned GW = GRP_W,
  localparam int unsigned AW = $clog2(CH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  output logic [CH-1:0] pwm_o
);
  logic [CW-1:0]      cnt;
  logic [GW-1:0]      grp;
  logic               wrap;
  chan_cfg_t [CH-1:0] act;

  ss_pwm_timebase #(.CW(CW), .GW(GW)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .grp_o  (grp),
    .wrap_o (wrap)
  );

  ss_pwm_regs #(.CH(CH), .CW(CW), .QW(QW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wrap_i    (wrap),
    .act_o     (act)
  );

  for (genvar ch = 0; ch < CH; ch++) begin : g_out
    ss_pwm_chan #(.CW(CW), .QW(QW), .GW(GW)) u_chan (
      .cfg_i (act[ch]),
      .cnt_i (cnt),
      .grp_i (grp),
      .pwm_o (pwm_o[ch])
    );
  end
endmodule

// File: rtl/ss_pwm_chk.sv
module ss_pwm_chk
  import ss_pwm_pkg::*;
#(
  parameter int unsigned CH = 4,
  parameter int unsigned CW = 10,
  parameter int unsigned GW = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [CH-1:0]      pwm_o,
  input logic [CW-1:0]      cnt_i,
  input logic [GW-1:0]      grp_i,
  input logic               wrap_i,
  input chan_cfg_t [CH-1:0] act_i
);
  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_i == CW'($past(cnt_i) + 1'b1));

  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pwm_o));

  // R3
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(act_i));

  // R6
  grp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> grp_i == GW'($past(grp_i) + 1'b1));

  // R6
  grp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(grp_i));

  // R8
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_out_chk: assert (pwm_o == '0);
    end
  end
endmodule

bind ss_pwm ss_pwm_chk #(.CH(CH), .CW(CW), .GW(GW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .pwm_o  (pwm_o),
  .cnt_i  (cnt),
  .grp_i  (grp),
  .wrap_i (wrap),
  .act_i  (act)
);

// File: tb/tb_ss_pwm.sv
module tb_ss_pwm;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] pwm_o;

  int total = 0;
  int bad = 0;
  int fnum = 0;
  int p_w[4], p_spr[4], p_sup[4];
  int a_w[4], a_spr[4], a_sup[4];
  int hi_cnt[4];
  int on_frames[4];

  always #5 clk_i = ~clk_i;

  ss_pwm dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .pwm_o(pwm_o)
  );

  // {chan, high byte, low byte, expected high count}
  localparam logic [29:0] VEC [8] = '{
    {2'd0, 8'h40, 8'h00, 12'd256},
    {2'd1, 8'h40, 8'hC1, 12'd259},
    {2'd2, 8'hFF, 8'hC0, 12'd1023},
    {2'd3, 8'hFF, 8'hC1, 12'd1023},
    {2'd0, 8'h00, 8'h40, 12'd1},
    {2'd1, 8'h00, 8'h41, 12'd1},
    {2'd2, 8'h00, 8'h01, 12'd0},
    {2'd3, 8'h80, 8'h8F, 12'd514}
  };

  function automatic bit exp_bit(int ch, int k);
    int w, q, off, len;
    bit blocked;
    w = a_w[ch];
    case (a_sup[ch])
      1: blocked = (fnum % 8) != 0;
      2: blocked = (fnum % 4) != 0;
      3: blocked = (fnum % 2) != 0;
      default: blocked = 0;
    endcase
    if (blocked) return 0;
    if (a_spr[ch] != 0) begin
      q = k / 256;
      off = k % 256;
      len = (w / 4) + ((q < (w % 4)) ? 1 : 0);
      return off < len;
    end
    return k < w;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_write(int a, int d);
    int ch;
    ch = a / 2;
    if (a % 2 == 1) begin
      p_w[ch] = (p_w[ch] % 4) + d * 4;
    end else begin
      p_w[ch]   = (p_w[ch] / 4) * 4 + (d / 64);
      p_sup[ch] = (d / 16) % 4;
      p_spr[ch] = d % 2;
    end
  endtask

  // Runs one frame, comparing every sample with the model.
  task automatic run_frame(string req, int wk, int wa0, int wd0, int wa1, int wd1,
                           int stall_k, int stall_n);
    int k = 0;
    int st = 0;
    bit fresh = 1;
    int mism[4];
    int f_act[4], f_exp[4], f_k[4];
    for (int c = 0; c < 4; c++) begin
      mism[c] = 0; hi_cnt[c] = 0; f_act[c] = 0; f_exp[c] = 0; f_k[c] = 0;
    end
    while (k < 1024) begin
      @(negedge clk_i);
      for (int c = 0; c < 4; c++) begin
        if (pwm_o[c] !== exp_bit(c, k)) begin
          if (mism[c] == 0) begin
            f_act[c] = pwm_o[c]; f_exp[c] = exp_bit(c, k); f_k[c] = k;
          end
          mism[c]++;
        end
        if (fresh && pwm_o[c] === 1'b1) hi_cnt[c]++;
      end
      wr_en_i = 1'b0;
      if (fresh && k == wk && wa0 >= 0) begin
        wr_en_i = 1'b1; wr_addr_i = 3'(wa0); wr_data_i = 8'(wd0);
        model_write(wa0, wd0);
      end else if (fresh && k == wk + 1 && wa1 >= 0) begin
        wr_en_i = 1'b1; wr_addr_i = 3'(wa1); wr_data_i = 8'(wd1);
        model_write(wa1, wd1);
      end
      if (k == stall_k && st < stall_n) begin
        tick_i = 1'b0; st++;
      end else begin
        tick_i = 1'b1;
      end
      fresh = tick_i;
      if (tick_i) begin
        if (k == 1023) begin
          for (int c = 0; c < 4; c++) begin
            a_w[c] = p_w[c]; a_spr[c] = p_spr[c]; a_sup[c] = p_sup[c];
          end
        end
        k++;
      end
    end
    for (int c = 0; c < 4; c++) begin
      if (mism[c] != 0)
        $display("  ch%0d frame %0d first mismatch at count %0d", c, fnum, f_k[c]);
      check(mism[c] == 0, req, $sformatf("ch%0d sample", c), f_act[c], f_exp[c]);
      if (hi_cnt[c] > 0) on_frames[c]++;
    end
    fnum++;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      p_w[c] = 0; p_spr[c] = 0; p_sup[c] = 0;
      a_w[c] = 0; a_spr[c] = 0; a_sup[c] = 0; on_frames[c] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R8 outputs low in reset
    check(pwm_o == 4'h0, "R8", "reset output", int'(pwm_o), 0);
    rst_ni = 1'b1;

    // R8 idle frame after reset
    run_frame("R8", -1, -1, 0, -1, 0, -1, 0);

    // vector table: write mid-frame (R3 old frame intact), then check next frame
    for (int i = 0; i < 8; i++) begin
      int ch, hb, lb, ex;
      ch = int'(VEC[i][29:28]); hb = int'(VEC[i][27:20]);
      lb = int'(VEC[i][19:12]); ex = int'(VEC[i][11:0]);
      run_frame("R3", 500, ch * 2 + 1, hb, ch * 2, lb, -1, 0);
      run_frame("R9", -1, -1, 0, -1, 0, -1, 0);
      // R4 flat, R5 spread, R2 field positions
      check(hi_cnt[ch] == ex, (lb % 2 == 1) ? "R5" : "R4",
            $sformatf("vec%0d high count", i), hi_cnt[ch], ex);
    end

    // R3 write on the wrap cycle takes effect in the new frame
    run_frame("R3", 1022, 1, 8'h10, 0, 8'h00, -1, 0);
    run_frame("R3", -1, -1, 0, -1, 0, -1, 0);
    check(hi_cnt[0] == 64, "R3", "wrap-cycle write count", hi_cnt[0], 64);

    // R7 stall mid-frame
    run_frame("R7", -1, -1, 0, -1, 0, 30, 40);
    check(hi_cnt[0] == 64, "R7", "stalled frame count", hi_cnt[0], 64);

    // R1 frame length: channel 3 spread value 514 repeats frame after frame
    check(hi_cnt[3] == 514, "R1", "steady frame count", hi_cnt[3], 514);

    // R6 suppression codes
    run_frame("R6", 100, 1, 8'h80, 0, 8'h10, -1, 0);
    run_frame("R6", 100, 3, 8'h80, 2, 8'h20, -1, 0);
    run_frame("R6", 100, 5, 8'h80, 4, 8'h30, -1, 0);
    for (int c = 0; c < 4; c++) on_frames[c] = 0;
    for (int f = 0; f < 8; f++) run_frame("R6", -1, -1, 0, -1, 0, -1, 0);
    check(on_frames[0] == 1, "R6", "code01 frames on", on_frames[0], 1);
    check(on_frames[1] == 2, "R6", "code10 frames on", on_frames[1], 2);
    check(on_frames[2] == 4, "R6", "code11 frames on", on_frames[2], 4);
    check(on_frames[3] == 8, "R9", "ch3 unaffected frames on", on_frames[3], 8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule